// File: doc/BRIEF.md
# 4B/5B Receive Symbol Aligner and Nibble Decoder

This block sits after the descrambler in a 100 Mb/s receive path. It takes a serial bit stream that has no known 5-bit code-group boundary. It looks for the start-of-stream delimiter pair, which must follow a run of idle bits. The position of that pair fixes the symbol boundary for the rest of the frame. From there the block emits one 4-bit nibble for every five received bits on a media-independent style interface. The output has a data bus, a one-cycle nibble strobe and a data-valid flag.

The two delimiter symbols come out as two preamble nibbles of value 0x5. Each later code group is translated through the 4B/5B data table. Output is delayed by one symbol, so the block can see the end-of-stream pair complete before it would emit its first half. The frame ends on that end pair, or at once if the link-ok or signal-detect input falls. A code group inside a frame that is not a data code gives a zero nibble with an error flag. Decoding then continues. Bits are qualified by a bit-enable input, so the line rate need not equal the clock rate.

Top module: `rx_symbol_decoder`

## Requirements
- R1: After synchronous reset, `rxdv`, `nib_stb`, `code_err` are 0 and `rxd` is 0.
- R2: Bits are taken in arrival order. A frame starts when the last ten accepted bits are 1100010001 (J then K) and the `IDLE_BITS` bits before them (default 10) are all 1. This can happen at any bit offset. On the clock edge that accepts the final K bit, `rxdv` rises and `nib_stb` pulses with `rxd` = 0x5.
- R3: A J/K pair preceded by fewer than `IDLE_BITS` consecutive ones does not start a frame.
- R4: A frame starts only while `lock`, `sig_det` and `link_ok` are all 1.
- R5: Inside a frame `nib_stb` pulses once per five accepted bits, on the edge that accepts each symbol's fifth bit. Each pulse carries the symbol completed five bits earlier. The second pulse is therefore the second 0x5 preamble nibble, and data nibbles follow in arrival order.
- R6: Data code groups decode as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. Bits are written in arrival order, and `rxd[0]` is the nibble LSB.
- R7: When the symbol pair T (01101) then R (00111) completes, `rxdv` falls on that edge and no strobe is given for T or R.
- R8: If `link_ok` or `sig_det` is 0 on an edge while in a frame, `rxdv` is 0 after that edge and no further strobe is given for that frame.
- R9: A code group in a frame that is not a data code and not part of T/R (for example idle 11111 or J) gives a strobe with `rxd` = 0 and `code_err` = 1 for that strobe only. The frame continues.
- R10: While `rxdv` is 0, `rxd` is 0 and `nib_stb` and `code_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Descrambled serial bit, arrival order |
| lock | input | 1 | Descrambler locked |
| sig_det | input | 1 | Signal detected on the line |
| link_ok | input | 1 | Link monitor reports a good link |
| rxd | output | 4 | Decoded nibble, bit 0 is LSB |
| nib_stb | output | 1 | One-cycle pulse per decoded nibble |
| rxdv | output | 1 | Frame data valid |
| code_err | output | 1 | Invalid code group in this strobe's nibble |

## Verification
The assertions assume that `bit_en` pulses are at least two cycles apart from one strobe to the next. They also assume that `lock`, `sig_det` and `link_ok` change only between clock edges, so the state they sample is the state the inputs held over the whole cycle. The stimulus drives every input at the falling edge. It sends bits either back to back or with inserted idle cycles, so any five-bit group spans at least five cycles and the strobe spacing assumption always holds. Frames are placed after runs of ones of varying length and with varying junk before them, so the delimiter is met at every bit offset.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;
    localparam int SYM_W  = 5;
    localparam int PAIR_W = 2 * SYM_W;

    localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R = 5'b00111;
    localparam logic [3:0]       PREAMBLE_NIB = 4'h5;

    typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] nib;
    } nib_code_t;

    typedef struct packed {
        logic       stb;
        logic       err;
        logic [3:0] nib;
    } nib_out_t;

    // Data code group lookup; anything else returns ok = 0.
    function automatic nib_code_t decode_sym(input logic [SYM_W-1:0] s);
        nib_code_t r;
        r.ok = 1'b1;
        unique case (s)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default: begin
                r.ok  = 1'b0;
                r.nib = 4'h0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rx_bit_window.sv
module rx_bit_window #(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_next
);
    logic [WIN_W-1:0] win_q;

    // Oldest bit at the MSB, newest bit enters at bit 0.
    assign win_next = {win_q[WIN_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_next;
        end
    end
endmodule

// File: rtl/rx_sym_decode.sv
module rx_sym_decode
    import rx4b5b_pkg::*;
(
    input  logic [PAIR_W-1:0] pair,
    output logic              is_start,
    output logic              is_end,
    output nib_code_t         prev_code
);
    logic [SYM_W-1:0] older;
    logic [SYM_W-1:0] newer;

    assign older     = pair[PAIR_W-1:SYM_W];
    assign newer     = pair[SYM_W-1:0];
    assign is_start  = (older == SYM_J) && (newer == SYM_K);
    assign is_end    = (older == SYM_T) && (newer == SYM_R);
    assign prev_code = decode_sym(older);
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx4b5b_pkg::*;
#(
    parameter int IDLE_BITS = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      idle_ok,
    input  logic      is_start,
    input  logic      is_end,
    input  nib_code_t prev_code,
    input  logic      lock,
    input  logic      sig_det,
    input  logic      link_ok,
    output nib_out_t  out_q,
    output logic      rxdv
);
    localparam int CNT_W = $clog2(SYM_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SYM_W - 1);

    rx_state_e        state_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             pre_pend_q;
    logic             line_good;

    assign line_good = sig_det && link_ok;
    assign rxdv      = (state_q == ST_FRAME);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HUNT;
            bit_cnt_q  <= '0;
            pre_pend_q <= 1'b0;
            out_q      <= '0;
        end else begin
            out_q.stb <= 1'b0;
            out_q.err <= 1'b0;
            unique case (state_q)
                ST_HUNT: begin
                    out_q.nib <= '0;
                    if (bit_en && is_start && idle_ok && lock && line_good) begin
                        state_q    <= ST_FRAME;
                        bit_cnt_q  <= '0;
                        pre_pend_q <= 1'b1;
                        out_q.stb  <= 1'b1;
                        out_q.nib  <= PREAMBLE_NIB;
                    end
                end
                ST_FRAME: begin
                    if (!line_good) begin
                        state_q   <= ST_HUNT;
                        out_q.nib <= '0;
                    end else if (bit_en) begin
                        if (bit_cnt_q == LAST_BIT) begin
                            bit_cnt_q <= '0;
                            if (pre_pend_q) begin
                                pre_pend_q <= 1'b0;
                                out_q.stb  <= 1'b1;
                                out_q.nib  <= PREAMBLE_NIB;
                            end else if (is_end) begin
                                state_q   <= ST_HUNT;
                                out_q.nib <= '0;
                            end else begin
                                out_q.stb <= 1'b1;
                                out_q.err <= !prev_code.ok;
                                out_q.nib <= prev_code.ok ? prev_code.nib : 4'h0;
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
    import rx4b5b_pkg::*;
#(
    parameter int IDLE_BITS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       lock,
    input  logic       sig_det,
    input  logic       link_ok,
    output logic [3:0] rxd,
    output logic       nib_stb,
    output logic       rxdv,
    output logic       code_err
);
    localparam int WIN_W = IDLE_BITS + PAIR_W;

    logic [WIN_W-1:0] win_next;
    logic             is_start;
    logic             is_end;
    logic             idle_ok;
    nib_code_t        prev_code;
    nib_out_t         out_q;

    rx_bit_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .win_next(win_next)
    );

    rx_sym_decode u_dec (
        .pair     (win_next[PAIR_W-1:0]),
        .is_start (is_start),
        .is_end   (is_end),
        .prev_code(prev_code)
    );

    assign idle_ok = &win_next[WIN_W-1:PAIR_W];

    rx_framer #(.IDLE_BITS(IDLE_BITS)) u_frm (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .idle_ok  (idle_ok),
        .is_start (is_start),
        .is_end   (is_end),
        .prev_code(prev_code),
        .lock     (lock),
        .sig_det  (sig_det),
        .link_ok  (link_ok),
        .out_q    (out_q),
        .rxdv     (rxdv)
    );

    assign rxd      = out_q.nib;
    assign nib_stb  = out_q.stb;
    assign code_err = out_q.err;
endmodule

// File: rtl/rx_symbol_decoder_chk.sv
module rx_symbol_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       lock,
    input logic       sig_det,
    input logic       link_ok,
    input logic [3:0] rxd,
    input logic       nib_stb,
    input logic       rxdv,
    input logic       code_err
);
    // R2
    start_nib_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rxdv) |-> (nib_stb && rxd == 4'h5 && !code_err));

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rxdv) |-> $past(lock && sig_det && link_ok && bit_en));

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        nib_stb |=> !nib_stb);

    // R5
    stb_from_bit_chk: assert property (@(posedge clk) disable iff (rst)
        nib_stb |-> $past(bit_en));

    // R8
    line_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rxdv && (!link_ok || !sig_det)) |=> !rxdv);

    // R9
    err_with_stb_chk: assert property (@(posedge clk) disable iff (rst)
        code_err |-> (nib_stb && rxd == 4'h0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rxdv |-> (rxd == 4'h0 && !nib_stb && !code_err));
endmodule

bind rx_symbol_decoder rx_symbol_decoder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .lock    (lock),
    .sig_det (sig_det),
    .link_ok (link_ok),
    .rxd     (rxd),
    .nib_stb (nib_stb),
    .rxdv    (rxdv),
    .code_err(code_err)
);

// File: tb/rx_symbol_decoder_bench.sv
module rx_symbol_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       lock = 1'b1;
    logic       sig_det = 1'b1;
    logic       link_ok = 1'b1;
    logic [3:0] rxd;
    logic       nib_stb;
    logic       rxdv;
    logic       code_err;

    int checks = 0;
    int fails = 0;
    int bitno = 0;
    int gap_mode = 0;
    int cap_cnt = 0;
    int quiet_bad = 0;
    int seen_dv = 0;
    bit done = 0;
    logic [3:0] cap_n [0:63];
    logic       cap_e [0:63];
    int         cap_p [0:63];

    always #5 clk = ~clk;

    rx_symbol_decoder u_rx_symbol_decoder (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .lock(lock), .sig_det(sig_det), .link_ok(link_ok),
        .rxd(rxd), .nib_stb(nib_stb), .rxdv(rxdv), .code_err(code_err)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic sample();
        if (nib_stb && cap_cnt < 64) begin
            cap_n[cap_cnt] = rxd;
            cap_e[cap_cnt] = code_err;
            cap_p[cap_cnt] = bitno;
            cap_cnt++;
        end
        if (rxdv) seen_dv = 1;
        if (!rxdv && (rxd != 4'h0 || nib_stb || code_err)) quiet_bad++;
    endtask

    task automatic send_bit(input logic b);
        if (gap_mode != 0 && (bitno % 3) == 0) begin
            @(negedge clk);
            bit_en = 1'b0;
            @(posedge clk); #1;
            sample();
        end
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        bitno++;
        @(posedge clk); #1;
        sample();
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) send_bit(s[i]);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic clear_cap();
        cap_cnt = 0;
        seen_dv = 0;
        quiet_bad = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int kpos;
        logic [3:0] d;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(rxdv == 0 && nib_stb == 0 && code_err == 0 && rxd == 0, "R1 reset outputs", {rxdv, nib_stb, code_err, rxd}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 R5 R6 R7 R10: sweep of offsets, idle lengths and all 16 nibbles
        for (int o = 0; o < 5; o++) begin
            clear_cap();
            gap_mode = o % 2;
            send_bit(1'b0);
            for (int j = 0; j < o; j++) send_bit(j[0]);
            send_bit(1'b0);
            send_ones(10 + o);
            send_sym(5'b11000);
            send_sym(5'b10001);
            kpos = bitno;
            for (int i = 0; i < 16; i++) begin
                d = 4'((o * 3 + i) % 16);
                send_sym(enc(d));
            end
            send_sym(5'b01101);
            chk(rxdv == 1, "R7 rxdv held before R", rxdv, 1);
            send_sym(5'b00111);
            chk(rxdv == 0 && rxd == 0, "R7 rxdv falls on T/R", rxdv, 0);
            send_ones(10);
            chk(cap_cnt == 18, "R5 strobe count per frame", cap_cnt, 18);
            for (int k = 0; k < 18 && k < cap_cnt; k++) begin
                if (k < 2) begin
                    chk(cap_n[k] == 4'h5, "R2 preamble nibble", cap_n[k], 5);
                end else begin
                    d = 4'((o * 3 + k - 2) % 16);
                    chk(cap_n[k] == d, "R6 decoded nibble", cap_n[k], d);
                end
                chk(cap_p[k] == kpos + 5 * k, "R5 strobe bit position", cap_p[k], kpos + 5 * k);
                chk(cap_e[k] == 0, "R9 no error on valid code", cap_e[k], 0);
            end
            chk(quiet_bad == 0, "R10 quiet outside frame", quiet_bad, 0);
        end
        gap_mode = 0;

        // R3: only nine ones before J
        clear_cap();
        send_bit(1'b0);
        send_ones(9);
        send_sym(5'b11000);
        send_sym(5'b10001);
        send_sym(enc(4'h1));
        send_sym(enc(4'h2));
        send_sym(5'b01101);
        send_sym(5'b00111);
        chk(cap_cnt == 0 && seen_dv == 0, "R3 short idle rejected", cap_cnt + seen_dv, 0);

        // R4: lock low, then sig_det low, block a start
        for (int m = 0; m < 3; m++) begin
            clear_cap();
            lock = (m != 0);
            link_ok = (m != 2);
            sig_det = (m != 1);
            send_bit(1'b0);
            send_ones(12);
            send_sym(5'b11000);
            send_sym(5'b10001);
            send_sym(enc(4'h3));
            send_sym(5'b01101);
            send_sym(5'b00111);
            chk(cap_cnt == 0 && seen_dv == 0, "R4 start gated by inputs", cap_cnt + seen_dv, 0);
            lock = 1'b1; sig_det = 1'b1; link_ok = 1'b1;
        end

        // R8: link_ok drop, then sig_det drop, inside a frame
        for (int m = 0; m < 2; m++) begin
            clear_cap();
            send_bit(1'b0);
            send_ones(10);
            send_sym(5'b11000);
            send_sym(5'b10001);
            send_sym(enc(4'h1));
            send_sym(enc(4'h2));
            send_sym(enc(4'h3));
            chk(rxdv == 1, "R8 frame active before drop", rxdv, 1);
            @(negedge clk);
            if (m == 0) link_ok = 1'b0; else sig_det = 1'b0;
            @(posedge clk); #1;
            chk(rxdv == 0 && rxd == 0, "R8 rxdv drops on line loss", {rxdv, rxd}, 0);
            send_sym(enc(4'h4));
            send_sym(enc(4'h5));
            send_sym(5'b01101);
            send_sym(5'b00111);
            chk(cap_cnt == 4, "R8 no strobes after drop", cap_cnt, 4);
            chk(cap_cnt >= 4 && cap_n[2] == 4'h1 && cap_n[3] == 4'h2, "R8 nibbles before drop", cap_n[3], 2);
            link_ok = 1'b1; sig_det = 1'b1;
        end

        // R9: idle and J inside a frame flag errors, frame continues
        clear_cap();
        send_bit(1'b0);
        send_ones(11);
        send_sym(5'b11000);
        send_sym(5'b10001);
        send_sym(enc(4'h1));
        send_sym(5'b11111);
        send_sym(enc(4'h2));
        send_sym(5'b11000);
        send_sym(enc(4'h3));
        send_sym(5'b01101);
        send_sym(5'b00111);
        chk(cap_cnt == 7, "R9 strobes with errors", cap_cnt, 7);
        for (int k = 0; k < 7 && k < cap_cnt; k++) begin
            chk(cap_e[k] == (k == 3 || k == 5), "R9 error flag position", cap_e[k], (k == 3 || k == 5));
        end
        chk(cap_cnt >= 7 && cap_n[3] == 0 && cap_n[4] == 4'h2 && cap_n[6] == 4'h3, "R9 nibbles around errors", cap_n[6], 3);
        chk(rxdv == 0 && quiet_bad == 0, "R10 idle after error frame", rxdv + quiet_bad, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule